// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit with Block Protection Keys

This unit sits between a processor's address generator and the memory port. It turns each logical address issued by the running process into a physical address by adding a base register, and it refuses any logical address that lies beyond a limit register. A second, switchable check splits physical memory into 2 KB blocks. Each block carries a 4-bit protection key held in a 16-entry table. An access is refused when the key of the block it lands in does not match the current key of the processor status.

A two-state mode machine governs who may change the configuration. In state SYS (privileged), writes to the base, the limit, the key table and the status key word take effect. In state USER, those writes are discarded and a one-cycle privilege-violation pulse is raised. The transition DROP (input `to_user`) moves SYS to USER. The transition TRAP (input `to_sys`) moves USER to SYS and wins when both inputs are high. Every request is answered exactly one cycle later with aligned valid, fault and address outputs, and a permission-to-issue strobe `rsp_go`.

Top module: `blr_reloc_unit`

## Requirements
- R1: For an accepted request, `rsp_paddr` equals base plus logical address, truncated to 16 bits; with base 0x9000 and logical 0x1204 it is 0xA204.
- R2: A logical address strictly greater than the limit sets `rsp_fault` and `rsp_limit_fault`; a logical address equal to the limit is translated.
- R3: Every request sampled with `req_valid` high yields `rsp_valid` high on the next cycle with all response outputs aligned, and the translation uses the register values held before any configuration write made in the same cycle.
- R4: In USER mode a configuration write changes no base, limit, key-table or status value, and raises `priv_viol` for exactly the following cycle; in SYS mode writes take effect and `priv_viol` stays low.
- R5: Configuration select codes are 0 base, 1 limit, 2 key-table entry (`cfg_idx`, data bits 3:0), and 3 status (data bits 3:0 current key, bit 4 key-check enable).
- R6: With key checking enabled, the block index is bits 14:11 of the physical address; a mismatch between that entry and the current key sets `rsp_fault` and `rsp_key_fault`. With key checking disabled no key fault occurs.
- R7: On any fault `rsp_paddr` is zero and `rsp_go` is low; otherwise `rsp_go` follows `rsp_valid`.
- R8: The mode machine moves SYS to USER on `to_user` alone and USER to SYS on `to_sys`; `mode_sys` reports SYS as 1.
- R9: Reset clears base, limit, all key entries, the current key and the enable, selects SYS mode, and holds all response outputs and `priv_viol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| to_user | input | 1 | Request transition DROP to USER mode |
| to_sys | input | 1 | Request transition TRAP to SYS mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_idx | input | 4 | Key-table entry index |
| cfg_wdata | input | 16 | Configuration write data |
| req_valid | input | 1 | Logical address valid |
| req_laddr | input | 16 | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Any fault on this response |
| rsp_limit_fault | output | 1 | Limit exceeded |
| rsp_key_fault | output | 1 | Protection key mismatch |
| rsp_paddr | output | 16 | Physical address, zero on fault |
| rsp_go | output | 1 | Memory access may be issued |
| priv_viol | output | 1 | User-mode configuration write seen last cycle |
| mode_sys | output | 1 | 1 in SYS mode |

## Verification
A configuration write and a translation can land in the same cycle. The bench provokes this by driving `cfg_we` and `req_valid` together, first in SYS mode, where the response must still reflect the old base and the next request the new one. It then does the same in USER mode, where the response must reflect the old base, `priv_viol` must pulse, and a following request must confirm that nothing changed. A limit fault and a key fault can also coincide, and the bench places one address beyond the limit inside a mismatching block and expects both flags.

// File: rtl/blr_pkg.sv
package blr_pkg;
    typedef enum logic [0:0] {
        MODE_SYS  = 1'b0,
        MODE_USER = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_KEYTAB = 2'd2,
        SEL_STATUS = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/blr_mode_fsm.sv
module blr_mode_fsm
    import blr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic to_user,
    input  logic to_sys,
    output logic mode_sys
);
    mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SYS;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SYS:  if (to_user && !to_sys) state_d = MODE_USER;
            MODE_USER: if (to_sys)             state_d = MODE_SYS;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_SYS:  mode_sys = 1'b1;
            MODE_USER: mode_sys = 1'b0;
        endcase
    end
endmodule

// File: rtl/blr_key_table.sv
module blr_key_table #(
    parameter int KEY_W   = 4,
    parameter int NUM_BLK = 16,
    localparam int IDX_W  = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key
);
    logic [KEY_W-1:0] key_q [NUM_BLK];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                key_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                key_q[g] <= wr_key;
        end
    end

    assign rd_key = key_q[rd_idx];
endmodule

// File: rtl/blr_xlate.sv
module blr_xlate #(
    parameter int AW      = 16,
    parameter int KEY_W   = 4,
    parameter int IDX_W   = 4,
    parameter int BLK_LSB = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    laddr,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    limit,
    input  logic             key_en,
    input  logic [KEY_W-1:0] cur_key,
    input  logic [KEY_W-1:0] blk_key,
    output logic [IDX_W-1:0] blk_idx,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic             rsp_limit_fault,
    output logic             rsp_key_fault,
    output logic [AW-1:0]    rsp_paddr,
    output logic             rsp_go
);
    logic [AW-1:0] sum;
    logic          over_limit;
    logic          key_miss;
    logic          valid_q, lf_q, kf_q;
    logic [AW-1:0] paddr_q;

    assign sum        = base + laddr;
    assign blk_idx    = sum[BLK_LSB +: IDX_W];
    assign over_limit = laddr > limit;
    assign key_miss   = key_en && (blk_key != cur_key);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            lf_q    <= 1'b0;
            kf_q    <= 1'b0;
            paddr_q <= '0;
        end else begin
            valid_q <= req_valid;
            lf_q    <= req_valid && over_limit;
            kf_q    <= req_valid && key_miss;
            paddr_q <= (req_valid && !over_limit && !key_miss) ? sum : '0;
        end
    end

    assign rsp_valid       = valid_q;
    assign rsp_limit_fault = lf_q;
    assign rsp_key_fault   = kf_q;
    assign rsp_fault       = lf_q | kf_q;
    assign rsp_paddr       = paddr_q;
    assign rsp_go          = valid_q & ~(lf_q | kf_q);
endmodule

// File: rtl/blr_reloc_unit.sv
module blr_reloc_unit
    import blr_pkg::*;
#(
    parameter int AW        = 16,
    parameter int KEY_W     = 4,
    parameter int NUM_BLK   = 16,
    parameter int BLK_BYTES = 2048,
    localparam int IDX_W    = $clog2(NUM_BLK),
    localparam int BLK_LSB  = $clog2(BLK_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             to_user,
    input  logic             to_sys,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [AW-1:0]    cfg_wdata,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_laddr,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic             rsp_limit_fault,
    output logic             rsp_key_fault,
    output logic [AW-1:0]    rsp_paddr,
    output logic             rsp_go,
    output logic             priv_viol,
    output logic             mode_sys
);
    logic [AW-1:0]    base_q, limit_q;
    logic [KEY_W-1:0] cur_key_q;
    logic             key_en_q;
    logic             priv_viol_q;
    logic             wr_ok;
    cfg_sel_e         sel;
    logic [IDX_W-1:0] blk_idx;
    logic [KEY_W-1:0] blk_key;

    blr_mode_fsm u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .to_user  (to_user),
        .to_sys   (to_sys),
        .mode_sys (mode_sys)
    );

    assign sel   = cfg_sel_e'(cfg_sel);
    assign wr_ok = cfg_we && mode_sys;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            limit_q     <= '0;
            cur_key_q   <= '0;
            key_en_q    <= 1'b0;
            priv_viol_q <= 1'b0;
        end else begin
            priv_viol_q <= cfg_we && !mode_sys;
            if (wr_ok) begin
                unique case (sel)
                    SEL_BASE:   base_q  <= cfg_wdata;
                    SEL_LIMIT:  limit_q <= cfg_wdata;
                    SEL_KEYTAB: ;
                    SEL_STATUS: begin
                        cur_key_q <= cfg_wdata[KEY_W-1:0];
                        key_en_q  <= cfg_wdata[KEY_W];
                    end
                endcase
            end
        end
    end

    assign priv_viol = priv_viol_q;

    blr_key_table #(.KEY_W(KEY_W), .NUM_BLK(NUM_BLK)) u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok && (sel == SEL_KEYTAB)),
        .wr_idx (cfg_idx),
        .wr_key (cfg_wdata[KEY_W-1:0]),
        .rd_idx (blk_idx),
        .rd_key (blk_key)
    );

    blr_xlate #(.AW(AW), .KEY_W(KEY_W), .IDX_W(IDX_W), .BLK_LSB(BLK_LSB)) u_xlate (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .laddr           (req_laddr),
        .base            (base_q),
        .limit           (limit_q),
        .key_en          (key_en_q),
        .cur_key         (cur_key_q),
        .blk_key         (blk_key),
        .blk_idx         (blk_idx),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault),
        .rsp_limit_fault (rsp_limit_fault),
        .rsp_key_fault   (rsp_key_fault),
        .rsp_paddr       (rsp_paddr),
        .rsp_go          (rsp_go)
    );
endmodule

// File: rtl/blr_reloc_unit_chk.sv
module blr_reloc_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_laddr,
    input logic          cfg_we,
    input logic          mode_sys,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] limit_q,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic          rsp_limit_fault,
    input logic [AW-1:0] rsp_paddr,
    input logic          priv_viol
);
    logic [AW-1:0] exp_sum;
    assign exp_sum = base_q + req_laddr;

    a_r1_sum: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_laddr <= limit_q) && !rsp_fault ##0 1'b1 |=> (rsp_fault || rsp_paddr == $past(exp_sum)));

    a_r2_limit: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_laddr > limit_q) |=> rsp_fault && rsp_limit_fault && rsp_paddr == '0);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r4_user_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !mode_sys |=> priv_viol && $stable(base_q) && $stable(limit_q));

    a_r4_sys_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !mode_sys) |=> !priv_viol);
endmodule

bind blr_reloc_unit blr_reloc_unit_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_laddr       (req_laddr),
    .cfg_we          (cfg_we),
    .mode_sys        (mode_sys),
    .base_q          (base_q),
    .limit_q         (limit_q),
    .rsp_valid       (rsp_valid),
    .rsp_fault       (rsp_fault),
    .rsp_limit_fault (rsp_limit_fault),
    .rsp_paddr       (rsp_paddr),
    .priv_viol       (priv_viol)
);

// File: tb/blr_reloc_unit_test.sv
`timescale 1ns/1ps
module blr_reloc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        to_user = 1'b0, to_sys = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [3:0]  cfg_idx = 4'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        req_valid = 1'b0;
    logic [15:0] req_laddr = 16'd0;
    logic        rsp_valid, rsp_fault, rsp_limit_fault, rsp_key_fault, rsp_go, priv_viol, mode_sys;
    logic [15:0] rsp_paddr;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_base = 0, m_lim = 0;
    logic [3:0]  m_tab [16];
    logic [3:0]  m_key = 0;
    logic        m_ken = 0;
    logic        m_sys = 1;

    always #2 clk = ~clk;

    blr_reloc_unit uut (
        .clk(clk), .rst_n(rst_n), .to_user(to_user), .to_sys(to_sys),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_laddr(req_laddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_limit_fault(rsp_limit_fault),
        .rsp_key_fault(rsp_key_fault), .rsp_paddr(rsp_paddr), .rsp_go(rsp_go),
        .priv_viol(priv_viol), .mode_sys(mode_sys)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_rsp(input string req, input logic [15:0] la, input logic [15:0] b);
        logic [15:0] pa;
        logic lf, kf;
        pa = b + la;
        lf = la > m_lim;
        kf = m_ken && (m_tab[pa[14:11]] != m_key);
        chk(req, "valid", rsp_valid, 1);
        chk(req, "limit_fault", rsp_limit_fault, lf);
        chk(req, "key_fault", rsp_key_fault, kf);
        chk(req, "fault", rsp_fault, lf | kf);
        chk(req, "paddr", rsp_paddr, (lf | kf) ? 16'h0 : pa);
        chk(req, "go", rsp_go, !(lf | kf));
    endtask

    task automatic xl(input string req, input logic [15:0] la);
        logic [15:0] b;
        b = m_base;
        req_valid = 1; req_laddr = la;
        @(negedge clk);
        req_valid = 0;
        check_rsp(req, la, b);
    endtask

    task automatic apply(input logic [1:0] sel, input logic [3:0] idx, input logic [15:0] d);
        if (m_sys) begin
            case (sel)
                2'd0: m_base = d;
                2'd1: m_lim = d;
                2'd2: m_tab[idx] = d[3:0];
                default: begin m_key = d[3:0]; m_ken = d[4]; end
            endcase
        end
    endtask

    task automatic wr(input string req, input logic [1:0] sel, input logic [3:0] idx, input logic [15:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        chk(req, "priv_viol", priv_viol, !m_sys);
        apply(sel, idx, d);
    endtask

    task automatic mode(input logic u, input logic s);
        to_user = u; to_sys = s;
        @(negedge clk);
        to_user = 0; to_sys = 0;
        if (s) m_sys = 1; else if (u) m_sys = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] bases [3];
        logic [15:0] lims [4];
        bases = '{16'h0000, 16'h9000, 16'hF800};
        lims  = '{16'h0000, 16'h07FF, 16'h2000, 16'hFFFF};
        for (int i = 0; i < 16; i++) m_tab[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        chk("R9", "rsp_valid", rsp_valid, 0);
        chk("R9", "priv_viol", priv_viol, 0);
        chk("R9", "mode_sys", mode_sys, 1);
        chk("R9", "rsp_go", rsp_go, 0);
        xl("R9", 16'h0000);
        xl("R9", 16'h0001);

        // R1 example
        wr("R5", 2'd0, 0, 16'h9000);
        wr("R5", 2'd1, 0, 16'h2000);
        xl("R1", 16'h1204);
        chk("R1", "example", rsp_paddr, 16'hA204);
        xl("R2", 16'h2000);
        xl("R2", 16'h2001);

        // R1 R2 R7 sweep
        for (int bi = 0; bi < 3; bi++) begin
            for (int li = 0; li < 4; li++) begin
                wr("R5", 2'd0, 0, bases[bi]);
                wr("R5", 2'd1, 0, lims[li]);
                for (int a = 0; a < 65536; a += 257) xl("R1", 16'(a));
                xl("R2", lims[li]);
            end
        end

        // R6 key mode
        wr("R5", 2'd0, 0, 16'h0000);
        wr("R5", 2'd1, 0, 16'hFFFF);
        for (int i = 0; i < 16; i++) wr("R5", 2'd2, 4'(i), 16'((i * 7 + 3) & 15));
        wr("R6", 2'd3, 0, 16'h0013);
        for (int i = 0; i < 32; i++) xl("R6", 16'(i * 16'h0800 + 16'h24));
        wr("R6", 2'd2, 4'd5, 16'h0003);
        xl("R6", 16'h2810);
        wr("R6", 2'd0, 0, 16'h0800);
        for (int i = 0; i < 32; i++) xl("R6", 16'(i * 16'h0800 + 16'h7F0));
        // both faults together
        wr("R2", 2'd1, 0, 16'h1000);
        xl("R2", 16'h3000);
        chk("R2", "dual limit", rsp_limit_fault, 1);
        chk("R6", "dual key", rsp_key_fault, 1);
        wr("R6", 2'd3, 0, 16'h0003);
        for (int i = 0; i < 16; i++) xl("R6", 16'(i * 16'h0800));

        // R3: write and request in the same cycle, SYS mode
        wr("R6", 2'd3, 0, 16'h0000);
        wr("R5", 2'd1, 0, 16'hFFFF);
        begin
            logic [15:0] ob;
            ob = m_base;
            cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 16'h1000;
            req_valid = 1; req_laddr = 16'h0010;
            @(negedge clk);
            cfg_we = 0; req_valid = 0;
            check_rsp("R3", 16'h0010, ob);
            chk("R3", "old base", rsp_paddr, 16'h0810);
            apply(2'd0, 0, 16'h1000);
        end
        xl("R3", 16'h0010);
        chk("R3", "new base", rsp_paddr, 16'h1010);
        @(negedge clk);
        chk("R3", "idle valid", rsp_valid, 0);

        // R8 / R4 user mode
        mode(1, 0);
        chk("R8", "to user", mode_sys, 0);
        wr("R4", 2'd0, 0, 16'h5555);
        @(negedge clk);
        chk("R4", "pulse ends", priv_viol, 0);
        wr("R4", 2'd1, 0, 16'h0001);
        wr("R4", 2'd2, 4'd2, 16'h000F);
        wr("R4", 2'd3, 0, 16'h001F);
        xl("R4", 16'h0020);
        xl("R4", 16'h1234);
        begin
            logic [15:0] ob;
            ob = m_base;
            cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 16'h7000;
            req_valid = 1; req_laddr = 16'h0044;
            @(negedge clk);
            cfg_we = 0; req_valid = 0;
            check_rsp("R4", 16'h0044, ob);
            chk("R4", "viol same cycle", priv_viol, 1);
        end
        xl("R4", 16'h0044);
        mode(1, 1);
        chk("R8", "trap wins", mode_sys, 1);
        mode(1, 1);
        chk("R8", "stay sys", mode_sys, 1);
        mode(0, 1);
        chk("R8", "sys hold", mode_sys, 1);
        wr("R4", 2'd0, 0, 16'h2000);
        xl("R4", 16'h0001);
        mode(1, 0);
        mode(0, 0);
        chk("R8", "user hold", mode_sys, 0);
        mode(0, 1);
        chk("R8", "trap", mode_sys, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule